// File: doc/BRIEF.md
# Configurable PLD Macrocell

This block is one logic cell of a programmable array. It takes the sum-of-products term that the AND plane produces for it. A polarity stage can pass that term, invert it, or combine it with a product term through an XOR. The result goes into a storage element whose behaviour is chosen at run time: an edge-triggered D flip-flop, a transparent latch, or a toggle flip-flop.

The storage element can also be loaded straight from the cell's pad input. In that case the stored value is a fast input register, while the combinational output still carries the logic function. Every control of the element is picked by static configuration inputs from a set of global lines and product-term lines:
- the clock,
- the clock enable,
- the preset,
- the reset,
- the pad output enable.

All clock sources are data signals. They are sampled on the one system clock `clk`, and an edge of a source is detected internally, so no clock is ever gated or muxed. Both the stored result (`q_out`) and the combinational result (`comb_out`) are always available for feedback. Either of them can drive the pad through `pad_out`.

Top module: `pld_macrocell`

## Requirements
- R1: While `rst_n` is low the stored value is cleared. After release, `q_out` reads 0 until the first load.
- R2: `cfg_pol` sets the polarity stage that drives `comb_out`. Code 0 passes `sop_in`. Code 1 inverts it. Code 2 gives `sop_in ^ pt_xor`. Code 3 gives the inverse of that XOR.
- R3: `cfg_clk_sel` picks the clock source. Codes 0 to 3 select `gclk[0..3]`, code 4 selects `pt_clk`, code 5 selects `shclk[0]` and code 6 selects `shclk[1]`. Code 7 means no clock. In D mode (`cfg_mode` 0 or 3), the data value is stored on the `clk` edge at which the selected source is sampled 1 after it was sampled 0 on the previous edge. `q_out` shows the new value after that edge.
- R4: In latch mode (`cfg_mode` 1), the data value is stored on every `clk` edge at which the selected source is sampled 1 and the enable is active. The stored value holds otherwise.
- R5: In toggle mode (`cfg_mode` 2), the stored value inverts on a detected source edge only when the data value is 1 and the enable is active.
- R6: `cfg_ce_sel` sets the enable. Code 0 is always on, code 1 is `gce`, code 2 is `pt_ce`, and code 3 is `gce & pt_ce`. When the enable is low, no mode changes the stored value.
- R7: `cfg_rst_sel` and `cfg_set_sel` each pick a source. Code 0 is none, code 1 is the global line (`grst` or `gset`), code 2 is the cell's own term (`pt_rst` or `pt_set`), code 3 is `sh_sr[0]` and code 4 is `sh_sr[1]`. Codes 5 to 7 mean none. An active reset forces `q_out` to 0 in the same cycle, without waiting for a clock edge. An active preset forces `q_out` to 1 the same way. Reset wins when both are active, and the forced value stays stored after release.
- R8: When `cfg_pad_load` is 1, the data value is `pad_in` instead of the polarity output. `comb_out` keeps carrying the polarity output either way.
- R9: `cfg_oe_sel` sets `pad_oe`. Codes 0 to 5 select `goe_pt[0..5]`, codes 6 and 7 select `goe_pin[0..1]`, code 8 selects `pt_oe` and code 9 is always on. Codes 10 to 15 keep the pad disabled.
- R10: `pad_out` equals `comb_out` when `cfg_out_comb` is 1, and equals `q_out` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all clock sources are sampled on it |
| rst_n | input | 1 | Active-low asynchronous block reset |
| cfg_mode | input | 2 | Storage mode: 0/3 D flip-flop, 1 latch, 2 toggle |
| cfg_pol | input | 2 | Polarity stage code |
| cfg_clk_sel | input | 3 | Clock source code |
| cfg_ce_sel | input | 2 | Enable source code |
| cfg_rst_sel | input | 3 | Reset source code |
| cfg_set_sel | input | 3 | Preset source code |
| cfg_pad_load | input | 1 | Load storage from the pad input |
| cfg_out_comb | input | 1 | Pad output carries the combinational result |
| cfg_oe_sel | input | 4 | Output-enable source code |
| sop_in | input | 1 | Sum-of-products term from the AND plane |
| pt_xor | input | 1 | Product term for the XOR polarity stage |
| gclk | input | 4 | Dedicated global clock lines |
| pt_clk | input | 1 | Per-cell product-term clock |
| shclk | input | 2 | Shared product-term clocks |
| gce | input | 1 | Global clock enable |
| pt_ce | input | 1 | Product-term clock enable |
| grst | input | 1 | Global reset |
| gset | input | 1 | Global preset |
| pt_rst | input | 1 | Per-cell product-term reset |
| pt_set | input | 1 | Per-cell product-term preset |
| sh_sr | input | 2 | Shared product-term set/reset lines |
| goe_pt | input | 6 | Global product-term output enables |
| goe_pin | input | 2 | Global output-enable pins |
| pt_oe | input | 1 | Per-cell product-term output enable |
| pad_in | input | 1 | Direct input from the pad |
| q_out | output | 1 | Stored result, with reset and preset applied |
| comb_out | output | 1 | Combinational result of the polarity stage |
| pad_out | output | 1 | Value driven toward the pad |
| pad_oe | output | 1 | Pad output enable |

## Verification
Two things can arrive in the same cycle: a detected edge or latch opening of the selected clock source, and an active reset or preset. Reset and preset can also both be active in one cycle. The random phase toggles every clock source freely while it pulses the global, per-cell and shared set/reset lines sparsely, so these collisions happen often and under every mode. A behavioural model in the bench lets the override win over the load and lets reset win over preset. It compares `q_out` against the model in the collision cycle and in the cycle after release, where the forced value must still be stored.

// File: rtl/pld_macrocell.sv
module pld_macrocell #(
  parameter int NUM_GCLK    = 4,
  parameter int NUM_GOE_PT  = 6,
  parameter int NUM_GOE_PIN = 2,
  localparam int CLK_N = NUM_GCLK + 3,
  localparam int OE_N  = NUM_GOE_PT + NUM_GOE_PIN + 2,
  localparam int CSW   = $clog2(CLK_N + 1),
  localparam int OSW   = $clog2(OE_N + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             cfg_mode,
  input  logic [1:0]             cfg_pol,
  input  logic [CSW-1:0]         cfg_clk_sel,
  input  logic [1:0]             cfg_ce_sel,
  input  logic [2:0]             cfg_rst_sel,
  input  logic [2:0]             cfg_set_sel,
  input  logic                   cfg_pad_load,
  input  logic                   cfg_out_comb,
  input  logic [OSW-1:0]         cfg_oe_sel,
  input  logic                   sop_in,
  input  logic                   pt_xor,
  input  logic [NUM_GCLK-1:0]    gclk,
  input  logic                   pt_clk,
  input  logic [1:0]             shclk,
  input  logic                   gce,
  input  logic                   pt_ce,
  input  logic                   grst,
  input  logic                   gset,
  input  logic                   pt_rst,
  input  logic                   pt_set,
  input  logic [1:0]             sh_sr,
  input  logic [NUM_GOE_PT-1:0]  goe_pt,
  input  logic [NUM_GOE_PIN-1:0] goe_pin,
  input  logic                   pt_oe,
  input  logic                   pad_in,
  output logic                   q_out,
  output logic                   comb_out,
  output logic                   pad_out,
  output logic                   pad_oe
);

  logic             pol_out, d_in, sel_clk, ce, rst_act, set_act, src_q, q_reg;
  logic [CLK_N-1:0] clk_vec;
  logic [OE_N-1:0]  oe_vec;

  always_comb begin
    case (cfg_pol)
      2'd1:    pol_out = ~sop_in;
      2'd2:    pol_out = sop_in ^ pt_xor;
      2'd3:    pol_out = ~(sop_in ^ pt_xor);
      default: pol_out = sop_in;
    endcase
  end

  assign d_in    = cfg_pad_load ? pad_in : pol_out;
  assign clk_vec = {shclk[1], shclk[0], pt_clk, gclk};
  assign sel_clk = (int'(cfg_clk_sel) < CLK_N) ? clk_vec[cfg_clk_sel] : 1'b0;

  always_comb begin
    case (cfg_ce_sel)
      2'd1:    ce = gce;
      2'd2:    ce = pt_ce;
      2'd3:    ce = gce & pt_ce;
      default: ce = 1'b1;
    endcase
  end

  always_comb begin
    case (cfg_rst_sel)
      3'd1:    rst_act = grst;
      3'd2:    rst_act = pt_rst;
      3'd3:    rst_act = sh_sr[0];
      3'd4:    rst_act = sh_sr[1];
      default: rst_act = 1'b0;
    endcase
    case (cfg_set_sel)
      3'd1:    set_act = gset;
      3'd2:    set_act = pt_set;
      3'd3:    set_act = sh_sr[0];
      3'd4:    set_act = sh_sr[1];
      default: set_act = 1'b0;
    endcase
  end

  wire src_edge = sel_clk & ~src_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_reg <= 1'b0;
      src_q <= 1'b0;
    end else begin
      src_q <= sel_clk;
      if (rst_act)      q_reg <= 1'b0;
      else if (set_act) q_reg <= 1'b1;
      else if (ce) begin
        case (cfg_mode)
          2'd1:    if (sel_clk)         q_reg <= d_in;
          2'd2:    if (src_edge & d_in) q_reg <= ~q_reg;
          default: if (src_edge)        q_reg <= d_in;
        endcase
      end
    end
  end

  assign q_out    = rst_act ? 1'b0 : (set_act ? 1'b1 : q_reg);
  assign comb_out = pol_out;
  assign pad_out  = cfg_out_comb ? comb_out : q_out;
  assign oe_vec   = {1'b1, pt_oe, goe_pin, goe_pt};
  assign pad_oe   = (int'(cfg_oe_sel) < OE_N) ? oe_vec[cfg_oe_sel] : 1'b0;

endmodule

// File: rtl/pld_macrocell_chk.sv
module pld_macrocell_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cfg_mode,
  input logic [1:0] cfg_pol,
  input logic [2:0] cfg_clk_sel,
  input logic [2:0] cfg_rst_sel,
  input logic [2:0] cfg_set_sel,
  input logic       cfg_pad_load,
  input logic [3:0] cfg_oe_sel,
  input logic       sop_in,
  input logic [3:0] gclk,
  input logic       grst,
  input logic       pt_set,
  input logic       q_out,
  input logic       comb_out,
  input logic       pad_oe
);

  assert_reset_forces_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rst_sel == 3'd1 && grst) |-> !q_out);

  assert_preset_forces_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rst_sel == 3'd0 && cfg_set_sel == 3'd2 && pt_set) |-> q_out);

  assert_no_edge_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'd0 && cfg_clk_sel == 3'd0 && !gclk[0] &&
     cfg_rst_sel == 3'd0 && cfg_set_sel == 3'd0)
    |=> (cfg_rst_sel != 3'd0 || cfg_set_sel != 3'd0 || $stable(q_out)));

  assert_toggle_zero_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'd2 && cfg_rst_sel == 3'd0 && cfg_set_sel == 3'd0 &&
     !cfg_pad_load && cfg_pol == 2'd0 && !sop_in)
    |=> (cfg_rst_sel != 3'd0 || cfg_set_sel != 3'd0 || $stable(q_out)));

  assert_comb_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_pol == 2'd0) |-> (comb_out == sop_in));

  assert_oe_always_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_oe_sel == 4'd9) |-> pad_oe);

  assert_oe_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_oe_sel > 4'd9) |-> !pad_oe);

endmodule

bind pld_macrocell pld_macrocell_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_pol(cfg_pol),
  .cfg_clk_sel(cfg_clk_sel), .cfg_rst_sel(cfg_rst_sel), .cfg_set_sel(cfg_set_sel),
  .cfg_pad_load(cfg_pad_load), .cfg_oe_sel(cfg_oe_sel), .sop_in(sop_in),
  .gclk(gclk), .grst(grst), .pt_set(pt_set), .q_out(q_out),
  .comb_out(comb_out), .pad_oe(pad_oe)
);

// File: tb/pld_macrocell_tb.sv
`timescale 1ns/1ps
module pld_macrocell_tb;
  logic clk = 0, rst_n = 0;
  logic [1:0] cfg_mode = 0, cfg_pol = 0, cfg_ce_sel = 0;
  logic [2:0] cfg_clk_sel = 0, cfg_rst_sel = 0, cfg_set_sel = 0;
  logic cfg_pad_load = 0, cfg_out_comb = 0;
  logic [3:0] cfg_oe_sel = 0;
  logic sop_in = 0, pt_xor = 0, pt_clk = 0, gce = 0, pt_ce = 0;
  logic grst = 0, gset = 0, pt_rst = 0, pt_set = 0, pt_oe = 0, pad_in = 0;
  logic [3:0] gclk = 0;
  logic [1:0] shclk = 0, sh_sr = 0, goe_pin = 0;
  logic [5:0] goe_pt = 0;
  logic q_out, comb_out, pad_out, pad_oe;

  int checks = 0, failures = 0;
  bit done = 0;
  bit mq = 0, mprev = 0;
  int sr_rate = 0;

  always #2 clk = ~clk;

  pld_macrocell u_dut (.*);

  function automatic bit m_pol();
    case (cfg_pol)
      1: return !sop_in;
      2: return sop_in ^ pt_xor;
      3: return !(sop_in ^ pt_xor);
      default: return sop_in;
    endcase
  endfunction
  function automatic bit m_d(); return cfg_pad_load ? pad_in : m_pol(); endfunction
  function automatic bit m_clk();
    if (cfg_clk_sel < 4) return gclk[cfg_clk_sel];
    if (cfg_clk_sel == 4) return pt_clk;
    if (cfg_clk_sel == 5) return shclk[0];
    if (cfg_clk_sel == 6) return shclk[1];
    return 0;
  endfunction
  function automatic bit m_ce();
    case (cfg_ce_sel) 1: return gce; 2: return pt_ce; 3: return gce && pt_ce; default: return 1; endcase
  endfunction
  function automatic bit m_pick(logic [2:0] c, bit g, bit p);
    case (c) 1: return g; 2: return p; 3: return sh_sr[0]; 4: return sh_sr[1]; default: return 0; endcase
  endfunction
  function automatic bit m_rst(); return m_pick(cfg_rst_sel, grst, pt_rst); endfunction
  function automatic bit m_set(); return m_pick(cfg_set_sel, gset, pt_set); endfunction
  function automatic bit m_q(); return m_rst() ? 0 : (m_set() ? 1 : mq); endfunction
  function automatic bit m_oe();
    if (cfg_oe_sel < 6) return goe_pt[cfg_oe_sel];
    if (cfg_oe_sel < 8) return goe_pin[cfg_oe_sel - 6];
    if (cfg_oe_sel == 8) return pt_oe;
    return cfg_oe_sel == 9;
  endfunction

  task automatic model_edge();
    bit s = m_clk();
    bit rise = s && !mprev;
    if (m_rst()) mq = 0;
    else if (m_set()) mq = 1;
    else if (m_ce()) begin
      if (cfg_mode == 1) begin if (s) mq = m_d(); end
      else if (cfg_mode == 2) begin if (rise && m_d()) mq = !mq; end
      else if (rise) mq = m_d();
    end
    mprev = s;
  endtask

  task automatic compare(string tag);
    bit eq = m_q(), ec = m_pol(), eo = m_oe();
    bit ep = cfg_out_comb ? ec : eq;
    checks++;
    if (q_out !== eq || comb_out !== ec || pad_out !== ep || pad_oe !== eo) begin
      failures++;
      $display("FAIL %s q=%b/%b comb=%b/%b pad=%b/%b oe=%b/%b (actual/expected)",
               tag, q_out, eq, comb_out, ec, pad_out, ep, pad_oe, eo);
    end
  endtask

  task automatic jiggle();
    {sop_in, pt_xor, pad_in, gce, pt_ce, pt_oe} = 6'($urandom);
    gclk = 4'($urandom); {pt_clk, shclk} = 3'($urandom);
    goe_pt = 6'($urandom); goe_pin = 2'($urandom);
    if (sr_rate > 0) begin
      grst   = ($urandom % sr_rate) == 0; gset   = ($urandom % sr_rate) == 0;
      pt_rst = ($urandom % sr_rate) == 0; pt_set = ($urandom % sr_rate) == 0;
      sh_sr  = {($urandom % sr_rate) == 0, ($urandom % sr_rate) == 0};
    end else begin
      {grst, gset, pt_rst, pt_set, sh_sr} = 0;
    end
  endtask

  task automatic step(string tag);
    @(posedge clk); model_edge();
    @(negedge clk); compare(tag);
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) begin jiggle(); step(tag); end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    gclk = 4'hF; cfg_mode = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (q_out !== 0) begin failures++; $display("FAIL R1 reset q=%b expected 0", q_out); end
    rst_n = 1; gclk = 0;
    step("R1");
    // D flop on each global clock and product-term clocks
    for (int c = 0; c < 8; c++) begin cfg_clk_sel = 3'(c); run(60, "R3"); end
    for (int p = 0; p < 4; p++) begin cfg_pol = 2'(p); cfg_clk_sel = 1; run(60, "R2"); end
    cfg_pol = 0; cfg_mode = 1; run(120, "R4");
    cfg_mode = 2; run(120, "R5");
    cfg_mode = 3; run(40, "R3");
    for (int e = 0; e < 4; e++) begin
      cfg_ce_sel = 2'(e);
      for (int m = 0; m < 3; m++) begin cfg_mode = 2'(m); run(40, "R6"); end
    end
    cfg_ce_sel = 0; cfg_mode = 0; sr_rate = 3;
    for (int r = 0; r < 8; r++) begin
      cfg_rst_sel = 3'(r); cfg_set_sel = 3'(7 - r); run(40, "R7");
      cfg_set_sel = 3'(r); run(40, "R7");
    end
    // reset and preset on the same line, reset must win
    cfg_rst_sel = 3; cfg_set_sel = 3; run(40, "R7");
    cfg_rst_sel = 0; cfg_set_sel = 0; sr_rate = 0;
    cfg_pad_load = 1; cfg_pol = 2; run(100, "R8");
    cfg_mode = 1; run(60, "R8");
    cfg_pad_load = 0;
    for (int o = 0; o < 16; o++) begin cfg_oe_sel = 4'(o); run(12, "R9"); end
    cfg_out_comb = 1; run(60, "R10");
    cfg_out_comb = 0; run(30, "R10");
    sr_rate = 6;
    for (int k = 0; k < 400; k++) begin
      cfg_mode = 2'($urandom); cfg_pol = 2'($urandom); cfg_clk_sel = 3'($urandom);
      cfg_ce_sel = 2'($urandom); cfg_rst_sel = 3'($urandom % 6); cfg_set_sel = 3'($urandom % 6);
      cfg_pad_load = 1'($urandom); cfg_out_comb = 1'($urandom); cfg_oe_sel = 4'($urandom);
      run(8, "R7 R3 collision");
    end
    // mid-run reset
    rst_n = 0; sr_rate = 0; cfg_rst_sel = 0; cfg_set_sel = 0; mq = 0; mprev = 0;
    @(negedge clk); checks++;
    if (q_out !== 0) begin failures++; $display("FAIL R1 q=%b expected 0", q_out); end
    rst_n = 1; gclk = 0; pt_clk = 0; shclk = 0;
    step("R1");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule